// File: doc/BRIEF.md
# Arbitrating Serial Byte Transmitter

This block puts one byte at a time onto a shared open-drain data line, for a bus master that may be competing with other masters. An external clock generator supplies one-cycle strobes for the falling and rising edges of the serial clock. After each falling strobe the block sets its pull-low enable for the next bit slot. At each rising strobe it compares the level it intended with the sampled line. A byte takes nine slots: eight data slots, most significant bit first, and then one acknowledge slot.

The block detects a lost arbitration one bit at a time. When it is releasing the line to send a 1 and the line reads low, it records the loss and the slot index. From that point it drives nothing more, but it keeps counting clock strobes until the byte ends. If the loss happens during an address byte and the master also has a slave function, it requests a switch to slave mode. A new transfer starts only while the bus is free. Further bytes of the same transfer are requested separately, and the block accepts them only while it still holds the bus.

Top module: `arb_byte_tx`

## Requirements
- R1: A start request is accepted only when the block is idle and `bus_free` is high. A start request at any other time is ignored: no pull-low and no `byte_done` follow.
- R2: Bits leave most significant bit first. One cycle after each of the first nine `scl_fall` strobes of a byte, `sda_pull` is 1 for a driven 0 and 0 for a driven 1 or for a released slot.
- R3: At an `scl_rise` strobe in a slot the block drives, an intended 1 with `sda_in` low sets `arb_lost` one cycle later. `lost_idx` then holds the slot number, where 0 to 7 are data bits from the MSB down and 8 is the acknowledge slot.
- R4: After a loss, `sda_pull` stays 0 for the rest of the byte.
- R5: The block keeps counting strobes after a loss. `byte_done` pulses for one cycle, one cycle after the tenth `scl_fall` of the byte, and `sda_pull` is 0 from then on.
- R6: For an address byte (`is_addr`=1) all eight data slots are driven and compared whatever `rx_mode` is. The acknowledge slot is released and not compared.
- R7: For a data byte with `rx_mode`=0 (transmitter), the data slots are driven and compared. The acknowledge slot is released, so a low acknowledge from the slave causes no loss.
- R8: For a data byte with `rx_mode`=1 (receiver), the data slots are released and not compared. The acknowledge slot drives `ack_nack` (0 = pull low for ACK, 1 = release for NACK) and is compared like a data bit.
- R9: `slave_switch` pulses for one cycle together with a loss, but only during an address byte and only when `slave_en`=1.
- R10: `arb_lost` and `lost_idx` hold until the next accepted start request clears them. A next-byte request is accepted only when the block is idle and has held the bus since its last accepted start without a loss. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request a new transfer (first byte) |
| next_req | input | 1 | Request the next byte of the current transfer |
| bus_free | input | 1 | Bus idle indication |
| tx_byte | input | 8 | Byte to send (DATA_W) |
| is_addr | input | 1 | Byte is an address byte |
| rx_mode | input | 1 | 1 = master receiver for data bytes |
| ack_nack | input | 1 | Acknowledge level to send in receiver mode |
| slave_en | input | 1 | Master also has a slave function |
| scl_rise | input | 1 | Serial clock rising-edge strobe |
| scl_fall | input | 1 | Serial clock falling-edge strobe |
| sda_in | input | 1 | Sampled data line |
| sda_pull | output | 1 | Pull data line low |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| lost_idx | output | 4 | Slot at which arbitration was lost |
| slave_switch | output | 1 | Request to change to slave mode |
| byte_done | output | 1 | End-of-byte strobe |
| busy | output | 1 | Byte in progress |

## Verification
The hardest situation to reach is a loss partway through a byte, followed by the rest of that byte. From there the block must stay silent yet still count strobes, and only then report the byte as complete. The bench models a competing master by making `sda_in` the wired-AND of the block's own pull-low and a second bit pattern. Patterns that differ at a chosen slot place the loss at bit 5 of an address byte, at the receiver acknowledge slot, or inside a transmitted data byte. The bench then follows each byte through its remaining slots, checks that next-byte requests are refused after the loss, and checks that the next start clears the flag.

// File: rtl/arb_tx_pkg.sv
// Shared types for the arbitrating byte transmitter.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package arb_tx_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/arb_slot_seq.sv
// Bit-slot sequencer: counts the serial clock strobes of one byte
// (DATA_W data slots plus one acknowledge slot).
// Assumes: scl_fall/scl_rise are single-cycle strobes, never both high.
module arb_slot_seq
    import arb_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLOT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              scl_fall,
    input  logic              scl_rise,
    output logic              busy,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] nxt_slot,
    output logic              place,
    output logic              sample,
    output logic              done
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(DATA_W);

    seq_state_t st;

    // State and slot counter advance on falling strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SEQ_IDLE;
            slot <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SEQ_IDLE:  if (accept) st <= SEQ_ARMED;
                SEQ_ARMED: if (scl_fall) begin
                    st   <= SEQ_RUN;
                    slot <= '0;
                end
                SEQ_RUN:   if (scl_fall) begin
                    if (slot == LAST) begin
                        st   <= SEQ_IDLE;
                        done <= 1'b1;
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
                default:   st <= SEQ_IDLE;
            endcase
        end
    end

    // Strobe decoding for the bit source and loss detector.
    always_comb begin
        busy     = (st != SEQ_IDLE);
        nxt_slot = (st == SEQ_ARMED) ? '0 : slot + 1'b1;
        place    = scl_fall && ((st == SEQ_ARMED) || (st == SEQ_RUN && slot != LAST));
        sample   = scl_rise && (st == SEQ_RUN);
    end

    assert_slot_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_RUN) |-> (slot <= LAST));
    assert_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(done));
endmodule

// File: rtl/arb_bit_src.sv
// Bit source: captures the byte and its mode at accept time and gives,
// for any slot index, the intended level and whether the slot is driven.
// Assumes: load is high only while the sequencer is idle.
module arb_bit_src #(
    parameter int DATA_W = 8,
    parameter int SLOT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              is_addr,
    input  logic              rx_mode,
    input  logic              ack_nack,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic [SLOT_W-1:0] nxt_slot,
    output logic              cur_bit,
    output logic              cur_own,
    output logic              nxt_bit,
    output logic              nxt_own,
    output logic              addr_q
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(DATA_W);

    logic [DATA_W-1:0] byte_q;
    logic              rx_q;
    logic              ack_q;

    // Capture the byte configuration when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            addr_q <= 1'b0;
            rx_q   <= 1'b0;
            ack_q  <= 1'b1;
        end else if (load) begin
            byte_q <= tx_byte;
            addr_q <= is_addr;
            rx_q   <= rx_mode;
            ack_q  <= ack_nack;
        end
    end

    function automatic logic slot_level(input logic [SLOT_W-1:0] idx);
        logic [DATA_W-1:0] sh;
        sh = byte_q << idx;
        return (idx == LAST) ? ack_q : sh[DATA_W-1];
    endfunction

    function automatic logic slot_owned(input logic [SLOT_W-1:0] idx);
        return (idx == LAST) ? (!addr_q && rx_q) : (addr_q || !rx_q);
    endfunction

    // Level and ownership for the slot being sampled and the one to place.
    always_comb begin
        cur_bit = slot_level(cur_slot);
        cur_own = slot_owned(cur_slot);
        nxt_bit = slot_level(nxt_slot);
        nxt_own = slot_owned(nxt_slot);
    end
endmodule

// File: rtl/arb_loss_det.sv
// Loss detector: compares the intended level with the sampled line at
// each rising strobe and keeps a sticky loss flag with its slot index.
// Assumes: clear only arrives while idle.
module arb_loss_det #(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              cur_own,
    input  logic              cur_bit,
    input  logic [SLOT_W-1:0] slot,
    input  logic              sda_in,
    input  logic              addr_q,
    input  logic              slave_en,
    output logic              lost_q,
    output logic [SLOT_W-1:0] lost_idx_q,
    output logic              switch_q
);
    logic lose;

    // A released high that reads low means another master holds the line.
    always_comb lose = sample && cur_own && cur_bit && !sda_in && !lost_q;

    // Sticky flag, index and the one-cycle slave hand-over pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost_q     <= 1'b0;
            lost_idx_q <= '0;
            switch_q   <= 1'b0;
        end else begin
            switch_q <= lose && addr_q && slave_en;
            if (clear) begin
                lost_q     <= 1'b0;
                lost_idx_q <= '0;
            end else if (lose) begin
                lost_q     <= 1'b1;
                lost_idx_q <= slot;
            end
        end
    end

    assert_loss_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_q) |-> ($past(sample) && !$past(sda_in)));
    assert_switch_needs_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        switch_q |-> (lost_q && addr_q));
    assert_idx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_q && $past(lost_q)) |-> $stable(lost_idx_q));
endmodule

// File: rtl/arb_byte_tx.sv
// Arbitrating serial byte transmitter top: accepts start and next-byte
// requests, drives the open-drain pull-low and reports arbitration loss.
// Assumes: an external generator supplies serial clock strobes and
// START/STOP; sda_in is already synchronised.
module arb_byte_tx #(
    parameter int DATA_W = 8,
    parameter int SLOT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              next_req,
    input  logic              bus_free,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              is_addr,
    input  logic              rx_mode,
    input  logic              ack_nack,
    input  logic              slave_en,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic              arb_lost,
    output logic [SLOT_W-1:0] lost_idx,
    output logic              slave_switch,
    output logic              byte_done,
    output logic              busy
);
    logic              acc_start, acc_next, accept;
    logic              owner_q;
    logic [SLOT_W-1:0] slot, nxt_slot;
    logic              place, sample;
    logic              cur_bit, cur_own, nxt_bit, nxt_own, addr_q;

    // Request acceptance: start needs a free bus, next needs ownership.
    always_comb begin
        acc_start = !busy && start_req && bus_free;
        acc_next  = !busy && !start_req && next_req && owner_q;
        accept    = acc_start || acc_next;
    end

    // Bus ownership held from an accepted start until a loss.
    always_ff @(posedge clk) begin
        if (!rst_n)         owner_q <= 1'b0;
        else if (acc_start) owner_q <= 1'b1;
        else if (arb_lost)  owner_q <= 1'b0;
    end

    arb_slot_seq #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .scl_fall(scl_fall), .scl_rise(scl_rise),
        .busy(busy), .slot(slot), .nxt_slot(nxt_slot),
        .place(place), .sample(sample), .done(byte_done)
    );

    arb_bit_src #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_src (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .tx_byte(tx_byte), .is_addr(is_addr), .rx_mode(rx_mode),
        .ack_nack(ack_nack), .cur_slot(slot), .nxt_slot(nxt_slot),
        .cur_bit(cur_bit), .cur_own(cur_own),
        .nxt_bit(nxt_bit), .nxt_own(nxt_own), .addr_q(addr_q)
    );

    arb_loss_det #(.SLOT_W(SLOT_W)) u_loss (
        .clk(clk), .rst_n(rst_n), .clear(acc_start),
        .sample(sample), .cur_own(cur_own), .cur_bit(cur_bit),
        .slot(slot), .sda_in(sda_in), .addr_q(addr_q),
        .slave_en(slave_en), .lost_q(arb_lost),
        .lost_idx_q(lost_idx), .switch_q(slave_switch)
    );

    // Pull-low register: new level after each falling strobe, silent after loss.
    always_ff @(posedge clk) begin
        if (!rst_n)        sda_pull <= 1'b0;
        else if (place)    sda_pull <= nxt_own && !nxt_bit && !arb_lost;
        else if (scl_fall) sda_pull <= 1'b0;
    end

    assert_ignore_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && !bus_free) |=> !busy);
    assert_quiet_after_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !sda_pull);
    assert_idle_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !sda_pull);
endmodule

// File: tb/test_arb_byte_tx.sv
module test_arb_byte_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 0, next_req = 0, bus_free = 1;
    logic [7:0] tx_byte = 0;
    logic       is_addr = 0, rx_mode = 0, ack_nack = 1, slave_en = 0;
    logic       scl_rise = 0, scl_fall = 0;
    logic       other_line = 1'b1;
    logic       sda_in;
    logic       sda_pull, arb_lost, slave_switch, byte_done, busy;
    logic [3:0] lost_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bit       m_owner = 0;
    bit       m_lost = 0;
    int       m_idx = 0;

    always #10 clk = ~clk;

    assign sda_in = ~sda_pull & other_line;

    arb_byte_tx i_arb_byte_tx (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .next_req(next_req),
        .bus_free(bus_free), .tx_byte(tx_byte), .is_addr(is_addr),
        .rx_mode(rx_mode), .ack_nack(ack_nack), .slave_en(slave_en),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .sda_pull(sda_pull), .arb_lost(arb_lost), .lost_idx(lost_idx),
        .slave_switch(slave_switch), .byte_done(byte_done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic strobe_fall();
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
    endtask

    task automatic strobe_rise();
        @(negedge clk) scl_rise = 1'b1;
        @(negedge clk) scl_rise = 1'b0;
    endtask

    // One byte with a competing master whose bits are 'other'/'oack'.
    task automatic run_byte(input string req, input bit use_start, input bit bfree,
                            input logic [7:0] data, input bit addr, input bit rxm,
                            input bit ackn, input bit slv,
                            input logic [7:0] other, input bit oack);
        bit acc, own, lvl, exp_pull, line, lose;
        @(negedge clk);
        bus_free = bfree; tx_byte = data; is_addr = addr; rx_mode = rxm;
        ack_nack = ackn; slave_en = slv;
        start_req = use_start; next_req = !use_start;
        acc = use_start ? bfree : m_owner;
        if (use_start && acc) begin m_owner = 1; m_lost = 0; m_idx = 0; end
        @(negedge clk) begin start_req = 0; next_req = 0; end
        chk(busy == acc, req, "request accepted", busy, acc);
        for (int s = 0; s < 9; s++) begin
            own = (s < 8) ? (addr || !rxm) : (!addr && rxm);
            lvl = (s < 8) ? data[7-s] : ackn;
            exp_pull = acc && own && !lvl && !m_lost;
            strobe_fall();
            chk(sda_pull == exp_pull, m_lost ? "R4" : req, $sformatf("pull slot %0d", s),
                sda_pull, exp_pull);
            @(negedge clk) other_line = (s < 8) ? other[7-s] : oack;
            line = !exp_pull && other_line;
            lose = acc && own && lvl && !line && !m_lost;
            strobe_rise();
            chk(slave_switch == (lose && addr && slv), "R9", $sformatf("switch slot %0d", s),
                slave_switch, lose && addr && slv);
            if (lose) begin m_lost = 1; m_idx = s; m_owner = 0; end
            chk(arb_lost == m_lost, "R3", $sformatf("lost flag slot %0d", s),
                arb_lost, m_lost);
            @(negedge clk) other_line = 1'b1;
        end
        strobe_fall();
        chk(byte_done == acc, "R5", "byte_done after tenth fall", byte_done, acc);
        chk(sda_pull == 1'b0, "R5", "line released at byte end", sda_pull, 0);
        if (m_lost)
            chk(lost_idx == m_idx, "R3", "lost index", lost_idx, m_idx);
        @(negedge clk);
        chk(byte_done == 1'b0, "R5", "byte_done single cycle", byte_done, 0);
        chk(arb_lost == m_lost, "R10", "sticky flag after byte", arb_lost, m_lost);
    endtask

    task automatic t_reset();
        chk(sda_pull == 0 && arb_lost == 0 && byte_done == 0 && slave_switch == 0 && busy == 0,
            "R1", "reset state", {sda_pull, arb_lost, byte_done, slave_switch, busy}, 0);
    endtask

    task automatic t_start_bus_busy();      // R1: ignored when bus not free
        run_byte("R1", 1, 0, 8'h00, 1, 0, 1, 0, 8'hFF, 1);
    endtask

    task automatic t_addr_clean();          // R2 R6: address, slave acks low
        run_byte("R6", 1, 1, 8'hA5, 1, 1, 1, 1, 8'hA5, 0);
    endtask

    task automatic t_data_tx();             // R2 R7: data tx, ack low no loss
        run_byte("R7", 0, 0, 8'h3C, 0, 0, 1, 1, 8'hFF, 0);
    endtask

    task automatic t_rx_ack();              // R8: receiver drives ACK low
        run_byte("R8", 0, 0, 8'h00, 0, 1, 0, 1, 8'h5A, 1);
    endtask

    task automatic t_rx_nack_lost();        // R8 R3: NACK overridden at slot 8
        run_byte("R8", 0, 0, 8'h00, 0, 1, 1, 1, 8'h96, 0);
    endtask

    task automatic t_next_after_loss();     // R10: next refused after loss
        run_byte("R10", 0, 1, 8'h00, 0, 0, 1, 0, 8'hFF, 1);
    endtask

    task automatic t_addr_loss_slave();     // R3 R4 R9: loss at slot 5
        run_byte("R2", 1, 1, 8'hA5, 1, 0, 1, 1, 8'hA1, 0);
    endtask

    task automatic t_addr_loss_noslave();   // R9: no switch without slave function
        run_byte("R9", 1, 1, 8'hF0, 1, 0, 1, 0, 8'h70, 0);
    endtask

    task automatic t_data_loss();           // R7 R9: loss in data byte, no switch
        run_byte("R2", 1, 1, 8'h42, 1, 0, 1, 1, 8'h42, 0);
        run_byte("R7", 0, 0, 8'hFF, 0, 0, 1, 1, 8'hFE, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_bus_busy();
        t_addr_clean();
        t_data_tx();
        t_rx_ack();
        t_rx_nack_lost();
        t_next_after_loss();
        t_addr_loss_slave();
        t_addr_loss_noslave();
        t_data_loss();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule